// File: doc/BRIEF.md
# Reference Clock Period Monitor with Hysteretic Fault Flag

This block watches one reference clock, supplied as a single-cycle pulse per rising edge that is already synchronous to the system clock. It counts system clock cycles from one pulse to the next and converts the count to femtoseconds. It then compares the result against a programmed nominal period. Two tolerances are programmed as reciprocals of the fractional limit. The tighter one, called inner, must be met before a faulted reference is cleared. The looser one, called outer, must be broken before a healthy reference is faulted. The gap between the two keeps the flag from toggling when the period sits near one limit.

While the system clock is reported unstable, the monitor does not measure and holds the fault flag set. If no edge arrives for more than twice the nominal period, the cycle counter stops and the reference is faulted. Every completed measurement is reported on a period output together with a one-cycle strobe.

Top module: `ref_period_mon`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `ref_fault`=1, `meas_done`=0 and `period_fs`=0.
- R2: The first `ref_tick` after reset, or after `sys_stable` returns high, only starts a measurement: `meas_done` stays 0 and `ref_fault` is unchanged.
- R3: Each later `ref_tick` seen at edge k, N cycles after the previous one, gives `period_fs` = N × SYS_FS_PER and `meas_done`=1 in cycle k+1 only. `period_fs` saturates at all ones if the product does not fit.
- R4: A nonfaulted reference becomes faulted on a measurement P when |P − nominal| × `tol_outer_rcp` > nominal. The tolerance fields hold 1/(fractional tolerance); for example, 20 means 5 %.
- R5: A faulted reference is cleared on a measurement P only when |P − nominal| × `tol_inner_rcp` ≤ nominal. Otherwise it stays faulted, even if P is within the outer tolerance.
- R6: A nonfaulted reference stays nonfaulted on a measurement within the outer tolerance, including deviation × reciprocal exactly equal to nominal.
- R7: While `sys_stable` is 0, `ref_fault` is 1 from the next cycle on, `meas_done` is 0, and edges are ignored.
- R8: When the cycle count reaches the first value C with C × SYS_FS_PER > 2 × nominal, the counter stops at C and `ref_fault` becomes 1 without a strobe. The next edge reports C × SYS_FS_PER.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sys_stable | input | 1 | High once the system clock is trusted |
| ref_tick | input | 1 | One-cycle pulse per reference rising edge |
| nom_period_fs | input | 40 | Nominal reference period in femtoseconds |
| tol_inner_rcp | input | 20 | Reciprocal of the inner (clearing) tolerance |
| tol_outer_rcp | input | 20 | Reciprocal of the outer (faulting) tolerance |
| ref_fault | output | 1 | Reference faulted |
| period_fs | output | 41 | Last measured period in femtoseconds |
| meas_done | output | 1 | One-cycle strobe when a measurement completes |

## Verification
The hardest situation to reach is the hysteresis band. A measurement there lies outside the inner tolerance but inside the outer one, and its result depends on the flag's history. The bench reaches it by first driving the flag high with a period beyond the outer limit. It then sends periods of 104 and 105 cycles, which must hold the fault, and sends the same deviations from the healthy state, which must not set it. The deviations exactly at each limit are included. The timeout is reached by idling more than twice the nominal period and then sending one edge, so that the stopped count can be read back on `period_fs`.

// File: rtl/refmon_pkg.sv
// Shared types for the reference period monitor.
package refmon_pkg;

    // Health of the monitored reference.
    typedef enum logic {
        REF_OK  = 1'b0,
        REF_BAD = 1'b1
    } ref_state_e;

endpackage

// File: rtl/refmon_counter.sv
// Counts system clock cycles between reference edge pulses.
// Assumes ref tick is synchronous, one cycle wide. Stops counting once the
// elapsed time exceeds twice the nominal period (timeout).
module refmon_counter #(
    parameter int              CNT_W  = 32,
    parameter int              PER_W  = 40,
    parameter logic [PER_W-1:0] SYS_FS = 40'd10_000_000,
    localparam int             MEAS_W = CNT_W + PER_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [PER_W-1:0]  nominal,
    output logic              armed,
    output logic [CNT_W-1:0]  cnt,
    output logic [MEAS_W-1:0] elapsed_fs,
    output logic              over_lim
);

    // Elapsed time and the timeout comparison against twice the nominal.
    always_comb begin
        elapsed_fs = MEAS_W'(cnt) * MEAS_W'(SYS_FS);
        over_lim   = armed && (elapsed_fs > MEAS_W'({nominal, 1'b0}));
    end

    // Counter: restart on each edge, hold at timeout or full scale.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (tick) begin
            cnt   <= CNT_W'(1);
            armed <= 1'b1;
        end else if (armed && !over_lim && (cnt != '1)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Counter holds once past the timeout limit.
    p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && over_lim && !tick) |=> $stable(cnt));

    // Arming happens only on an edge.
    p_arm_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(tick));

endmodule

// File: rtl/refmon_tol.sv
// Combinational tolerance test for one measured period.
// A tolerance is given as its reciprocal R; deviation d breaks it when
// d*R > nominal. Wide products avoid any division.
module refmon_tol #(
    parameter int MEAS_W = 72,
    parameter int PER_W  = 40,
    parameter int TOL_W  = 20,
    localparam int PROD_W = MEAS_W + TOL_W
) (
    input  logic [MEAS_W-1:0] meas_fs,
    input  logic [PER_W-1:0]  nominal,
    input  logic [TOL_W-1:0]  rcp_inner,
    input  logic [TOL_W-1:0]  rcp_outer,
    output logic              brk_inner,
    output logic              brk_outer
);

    logic [MEAS_W-1:0] nom_w;
    logic [MEAS_W-1:0] dev;
    logic [PROD_W-1:0] prod_in;
    logic [PROD_W-1:0] prod_out;

    // Absolute deviation and both scaled comparisons.
    always_comb begin
        nom_w     = MEAS_W'(nominal);
        dev       = (meas_fs >= nom_w) ? (meas_fs - nom_w) : (nom_w - meas_fs);
        prod_in   = PROD_W'(dev) * PROD_W'(rcp_inner);
        prod_out  = PROD_W'(dev) * PROD_W'(rcp_outer);
        brk_inner = prod_in  > PROD_W'(nominal);
        brk_outer = prod_out > PROD_W'(nominal);
    end

endmodule

// File: rtl/refmon_fault.sv
// Hysteretic fault state. Faulted clears only inside the inner tolerance;
// healthy faults only outside the outer tolerance, on timeout, or when the
// system clock is not stable.
module refmon_fault
    import refmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic dec_valid,
    input  logic brk_inner,
    input  logic brk_outer,
    input  logic timeout,
    output logic fault
);

    ref_state_e st_q;
    ref_state_e st_d;

    // Next-state selection with hysteresis.
    always_comb begin
        st_d = st_q;
        if (!run || timeout) begin
            st_d = REF_BAD;
        end else if (dec_valid) begin
            if (st_q == REF_OK && brk_outer) begin
                st_d = REF_BAD;
            end else if (st_q == REF_BAD && !brk_inner) begin
                st_d = REF_OK;
            end
        end
    end

    // State register, faulted out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= REF_BAD;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault = (st_q == REF_BAD);

    // Clearing requires a measurement inside the inner tolerance.
    p_clear_inner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> $past(run && dec_valid && !brk_inner));

    // Setting requires a cause.
    p_set_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(!run || timeout || (dec_valid && brk_outer)));

    // Healthy reference inside outer tolerance stays healthy.
    p_hold_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && run && dec_valid && !brk_outer && !timeout) |=> !fault);

endmodule

// File: rtl/ref_period_mon.sv
// Reference period monitor: measures each reference period in femtoseconds
// and maintains a hysteretic fault flag. Assumes ref_tick is synchronized.
module ref_period_mon #(
    parameter int              CNT_W      = 32,
    parameter int              PER_W      = 40,
    parameter int              TOL_W      = 20,
    parameter logic [PER_W-1:0] SYS_FS_PER = 40'd10_000_000,
    localparam int             MEAS_W     = CNT_W + PER_W,
    localparam int             OUT_W      = PER_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_stable,
    input  logic             ref_tick,
    input  logic [PER_W-1:0] nom_period_fs,
    input  logic [TOL_W-1:0] tol_inner_rcp,
    input  logic [TOL_W-1:0] tol_outer_rcp,
    output logic             ref_fault,
    output logic [OUT_W-1:0] period_fs,
    output logic             meas_done
);

    logic              armed;
    logic [CNT_W-1:0]  cnt;
    logic [MEAS_W-1:0] elapsed_fs;
    logic              over_lim;
    logic              brk_inner;
    logic              brk_outer;
    logic              dec_valid;
    logic              timeout;
    logic [OUT_W-1:0]  period_sat;

    refmon_counter #(
        .CNT_W (CNT_W),
        .PER_W (PER_W),
        .SYS_FS(SYS_FS_PER)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (sys_stable),
        .tick      (ref_tick),
        .nominal   (nom_period_fs),
        .armed     (armed),
        .cnt       (cnt),
        .elapsed_fs(elapsed_fs),
        .over_lim  (over_lim)
    );

    refmon_tol #(
        .MEAS_W(MEAS_W),
        .PER_W (PER_W),
        .TOL_W (TOL_W)
    ) u_tol (
        .meas_fs  (elapsed_fs),
        .nominal  (nom_period_fs),
        .rcp_inner(tol_inner_rcp),
        .rcp_outer(tol_outer_rcp),
        .brk_inner(brk_inner),
        .brk_outer(brk_outer)
    );

    // Decision and timeout qualifiers.
    always_comb begin
        dec_valid  = sys_stable && ref_tick && armed;
        timeout    = sys_stable && over_lim && !ref_tick;
        period_sat = (|elapsed_fs[MEAS_W-1:OUT_W]) ? '1 : elapsed_fs[OUT_W-1:0];
    end

    refmon_fault u_flt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (sys_stable),
        .dec_valid(dec_valid),
        .brk_inner(brk_inner),
        .brk_outer(brk_outer),
        .timeout  (timeout),
        .fault    (ref_fault)
    );

    // Capture the measured period and raise the done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_fs <= '0;
            meas_done <= 1'b0;
        end else begin
            meas_done <= dec_valid;
            if (dec_valid) begin
                period_fs <= period_sat;
            end
        end
    end

    // Strobe only follows an edge seen while stable.
    p_done_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |-> $past(ref_tick && sys_stable));

    // Unstable system clock forces fault and silences the strobe.
    p_unstable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_stable |=> (ref_fault && !meas_done));

    // Period output changes only with a strobe.
    p_period_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_done |-> $stable(period_fs) || $past(!rst_n));

endmodule

// File: tb/sim_ref_period_mon.sv
module sim_ref_period_mon;

    localparam int CLK_NS = 10;
    localparam logic [39:0] SYS_FS = 40'd10_000_000;
    localparam logic [39:0] NOM    = 40'd1_000_000_000; // 100 cycles
    localparam int NVEC = 12;
    // {period in cycles, expected fault after it}; outer 5 %, inner 2 %
    localparam logic [16:0] VEC [NVEC] = '{
        {16'd100, 1'b0}, {16'd104, 1'b0}, {16'd106, 1'b1}, {16'd104, 1'b1},
        {16'd105, 1'b1}, {16'd102, 1'b0}, {16'd95,  1'b0}, {16'd94,  1'b1},
        {16'd98,  1'b0}, {16'd105, 1'b0}, {16'd97,  1'b0}, {16'd100, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sys_stable = 1'b0;
    logic        ref_tick = 1'b0;
    logic [19:0] tol_in = 20'd50;
    logic [19:0] tol_out = 20'd20;
    logic        ref_fault;
    logic [40:0] period_fs;
    logic        meas_done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    ref_period_mon u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .sys_stable   (sys_stable),
        .ref_tick     (ref_tick),
        .nom_period_fs(NOM),
        .tol_inner_rcp(tol_in),
        .tol_outer_rcp(tol_out),
        .ref_fault    (ref_fault),
        .period_fs    (period_fs),
        .meas_done    (meas_done)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Tick n cycles after the previous tick; returns at the negedge after it.
    task automatic send_period(input int n);
        repeat (n - 1) @(negedge clk);
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 fault", 64'(ref_fault), 64'd1);
        chk("R1 done", 64'(meas_done), 64'd0);
        chk("R1 period", 64'(period_fs), 64'd0);
        rst_n = 1'b1;
        sys_stable = 1'b1;
        repeat (3) @(negedge clk);

        // R2: first edge only arms
        send_period(1);
        chk("R2 done", 64'(meas_done), 64'd0);
        chk("R2 fault", 64'(ref_fault), 64'd1);

        // R3..R6: table walk
        for (int i = 0; i < NVEC; i++) begin
            send_period(int'(VEC[i][16:1]));
            chk("R3 period", 64'(period_fs), 64'(VEC[i][16:1]) * 64'(SYS_FS));
            chk("R3 done", 64'(meas_done), 64'd1);
            chk(VEC[i][0] ? "R4/R5 fault" : "R5/R6 fault", 64'(ref_fault), 64'(VEC[i][0]));
        end
        @(negedge clk);
        chk("R3 done one cycle", 64'(meas_done), 64'd0);

        // R8: timeout after twice nominal; counter stops at 201
        repeat (250) @(negedge clk);
        chk("R8 fault", 64'(ref_fault), 64'd1);
        chk("R8 no done", 64'(meas_done), 64'd0);
        send_period(1);
        chk("R8 period", 64'(period_fs), 64'd201 * 64'(SYS_FS));
        chk("R8 done", 64'(meas_done), 64'd1);
        chk("R8 fault stays", 64'(ref_fault), 64'd1);
        send_period(100);
        chk("R5 recover", 64'(ref_fault), 64'd0);

        // R7: unstable system clock
        sys_stable = 1'b0;
        @(negedge clk);
        chk("R7 fault", 64'(ref_fault), 64'd1);
        send_period(100);
        chk("R7 no done", 64'(meas_done), 64'd0);
        chk("R7 fault held", 64'(ref_fault), 64'd1);
        chk("R7 period kept", 64'(period_fs), 64'd100 * 64'(SYS_FS));
        sys_stable = 1'b1;
        send_period(100);
        chk("R2 rearm no done", 64'(meas_done), 64'd0);
        send_period(100);
        chk("R7 resume done", 64'(meas_done), 64'd1);
        chk("R7 resume fault", 64'(ref_fault), 64'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule